// File: doc/BRIEF.md
# Line-Straddling Access Miss Counter

This block watches a stream of data accesses and counts how many of them could have missed in a small direct-mapped data cache, and how many did. It keeps only a tag and a valid bit per line. Each access brings an address, a byte length and a kind (read, write, or read-modify-write). The block works out whether the bytes run past the end of a line. It looks up one line, or two lines on consecutive cycles, and allocates every line that is absent. It then bumps a reference counter and, when needed, a miss counter.

An access that spans two lines still counts as a single reference. It is a miss when either line was absent. A read-modify-write counts as one read only, because its write part always finds the line its read just brought in. The reference count is therefore the number of chances for a miss, not the number of port transfers. A synchronous clear zeroes both counters and invalidates every tag.

Top module: `span_miss_counter`

## Requirements
- R1: After reset or a one-cycle `clr` pulse, both counters read 0, `busy` is low, and the next access to any line is a miss.
- R2: An access within one line whose line is absent adds one reference and one miss and allocates the line. A later access to that line adds one reference and no miss.
- R3: An access spans two lines exactly when (address mod 64) + (`req_len_m1` + 1) > 64. A spanning access holds `busy` high for exactly one cycle after it is taken. A non-spanning access never raises `busy`.
- R4: A spanning access that finds both lines present adds one reference and no miss.
- R5: A spanning access that finds exactly one of its two lines absent adds one reference and one miss. Afterwards both lines are present.
- R6: A spanning access that finds both lines absent adds one reference and one miss, not two. Both lines are allocated.
- R7: `req_kind` encodes 0 = read, 1 = write, 2 = read-modify-write. A write or a read-modify-write counts like a read: one reference, and a miss that allocates the line when it is absent.
- R8: A request with `req_kind` = 3 is dropped. It changes neither counter, allocates no line and does not raise `busy`.
- R9: Each counter stops at its all-ones value and stays there, and `miss_count` never exceeds `ref_count`.
- R10: Lines whose line addresses agree in their low 8 bits share one slot. Accessing one evicts the other, so the next access to the evicted line misses.
- R11: A request presented while `busy` is high, or in the same cycle as `clr`, is ignored. Counters move one cycle after the access completes and by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of counters and valid bits |
| req_valid | input | 1 | Access present this cycle |
| req_addr | input | ADDR_W (32) | Byte address of the first byte |
| req_len_m1 | input | LEN_W (4) | Access length in bytes minus one (1 to 16 bytes) |
| req_kind | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 reserved |
| busy | output | 1 | Second line of a spanning access is being looked up |
| ref_count | output | CNT_W (32) | Saturating count of references |
| miss_count | output | CNT_W (32) | Saturating count of misses |

## Verification
A stale or wrong tag does not show up on the spot. It shows up one cycle after the next access to that slot, as a miss that should have been a hit or the reverse. The stimulus therefore revisits lines right after filling, spanning and evicting them. A broken merge of the two lookups changes `miss_count` by the wrong amount in the cycle after `busy` falls. A broken length test shows up as `busy` rising, or failing to rise, in the cycle after the request is taken. Dropped or phantom requests show up as counts that are off on the next access to the affected line.

// File: rtl/span_miss_pkg.sv
package span_miss_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_RMW   = 2'd2,
        KIND_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    // Every defined kind is a single miss opportunity; only the reserved code is rejected.
    function automatic logic kind_counts(input logic [1:0] code);
        return acc_kind_e'(code) != KIND_RSVD;
    endfunction

endpackage

// File: rtl/span_miss_tags.sv
module span_miss_tags #(
    parameter int LA_W  = 26,
    parameter int IDX_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic [LA_W-1:0] look_line,
    output logic            look_hit,
    input  logic            fill_en
);
    localparam int SLOTS = 1 << IDX_W;
    localparam int TAG_W = LA_W - IDX_W;

    logic [SLOTS-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [SLOTS];

    logic [IDX_W-1:0] slot;
    logic [TAG_W-1:0] tag;

    assign slot     = look_line[IDX_W-1:0];
    assign tag      = look_line[LA_W-1:IDX_W];
    assign look_hit = valid_q[slot] && (tag_q[slot] == tag);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[slot] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !rst && !clr) begin
            tag_q[slot] <= tag;
        end
    end

    // R2: a filled slot holds the requested tag in the following cycle
    p_fill_sticks_r2: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !clr) |=> (valid_q[$past(slot)] && tag_q[$past(slot)] == $past(tag)));

endmodule

// File: rtl/span_miss_count.sv
module span_miss_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tally,
    input  logic             tally_miss,
    output logic [CNT_W-1:0] refs,
    output logic [CNT_W-1:0] misses
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] refs_q;
    logic [CNT_W-1:0] miss_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            refs_q <= '0;
            miss_q <= '0;
        end else if (tally) begin
            if (refs_q != TOP) refs_q <= refs_q + CNT_W'(1);
            if (tally_miss && miss_q != TOP) miss_q <= miss_q + CNT_W'(1);
        end
    end

    assign refs   = refs_q;
    assign misses = miss_q;

    // R9: saturated reference count stays put until cleared
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (refs_q == TOP && !clr) |=> refs_q == TOP);

    // R9: misses never outnumber references
    p_miss_le_ref_r9: assert property (@(posedge clk) disable iff (rst)
        miss_q <= refs_q);

    // R11, R6: at most one reference per cycle, so a spanning access is counted once
    p_count_once_r6: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (refs_q - $past(refs_q)) <= CNT_W'(1));

endmodule

// File: rtl/span_miss_counter.sv
module span_miss_counter
    import span_miss_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int LINES      = 256,
    parameter int LEN_W      = 4,
    parameter int CNT_W      = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len_m1,
    input  logic [1:0]        req_kind,
    output logic              busy,
    output logic [CNT_W-1:0]  ref_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(LINES);
    localparam int LA_W  = ADDR_W - OFF_W;

    phase_e          phase_q;
    logic [LA_W-1:0] second_line_q;
    logic            first_miss_q;

    logic [LA_W-1:0] req_line;
    logic [OFF_W:0]  last_byte;
    logic            spans;
    logic            take;
    logic [LA_W-1:0] look_line;
    logic            look_hit;
    logic            look_en;
    logic            done;
    logic            done_miss;

    assign req_line  = req_addr[ADDR_W-1:OFF_W];
    assign last_byte = {1'b0, req_addr[OFF_W-1:0]} + (OFF_W+1)'(req_len_m1);
    assign spans     = last_byte[OFF_W];

    assign busy      = (phase_q == PH_SECOND);
    assign take      = req_valid && !clr && !busy && kind_counts(req_kind);
    assign look_line = busy ? second_line_q : req_line;
    assign look_en   = take || (busy && !clr);

    assign done      = (take && !spans) || (busy && !clr);
    assign done_miss = busy ? (first_miss_q || !look_hit) : !look_hit;

    span_miss_tags #(
        .LA_W  (LA_W),
        .IDX_W (IDX_W)
    ) u_tags (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .look_line (look_line),
        .look_hit  (look_hit),
        .fill_en   (look_en && !look_hit)
    );

    span_miss_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .tally      (done),
        .tally_miss (done_miss),
        .refs       (ref_count),
        .misses     (miss_count)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q       <= PH_FIRST;
            second_line_q <= '0;
            first_miss_q  <= 1'b0;
        end else if (take && spans) begin
            phase_q       <= PH_SECOND;
            second_line_q <= req_line + LA_W'(1);
            first_miss_q  <= !look_hit;
        end else if (busy) begin
            phase_q       <= PH_FIRST;
        end
    end

    // R3: the second lookup takes exactly one extra cycle
    p_busy_single_r3: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    // R8: a reserved kind never starts the second-line phase
    p_rsvd_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && req_kind == 2'd3) |=> !busy);

endmodule

// File: tb/span_miss_counter_test.sv
`timescale 1ns/1ps
module span_miss_counter_test;

    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr = 1'b0;
    logic          req_valid = 1'b0;
    logic [31:0]   req_addr = '0;
    logic [3:0]    req_len_m1 = '0;
    logic [1:0]    req_kind = '0;
    logic          busy;
    logic [CW-1:0] ref_count;
    logic [CW-1:0] miss_count;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    span_miss_counter #(.CNT_W(CW)) uut (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_len_m1 (req_len_m1),
        .req_kind   (req_kind),
        .busy       (busy),
        .ref_count  (ref_count),
        .miss_count (miss_count)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [3:0]  l;
        logic [1:0]  k;
        logic        s;
        logic [7:0]  r;
        logic [7:0]  m;
    } row_t;

    localparam int NROW = 21;
    localparam row_t TBL [NROW] = '{
        '{32'h1000, 4'd3,  2'd0, 1'b0, 8'd1,  8'd1},  // R2 cold line
        '{32'h1008, 4'd7,  2'd0, 1'b0, 8'd2,  8'd1},  // R2 hit after fill
        '{32'h103C, 4'd7,  2'd0, 1'b1, 8'd3,  8'd2},  // R5 first hits, second misses
        '{32'h1038, 4'd15, 2'd0, 1'b1, 8'd4,  8'd2},  // R4 both hit
        '{32'h2000, 4'd3,  2'd1, 1'b0, 8'd5,  8'd3},  // R7 write miss allocates
        '{32'h2000, 4'd0,  2'd0, 1'b0, 8'd6,  8'd3},  // R7 line present after write
        '{32'h3010, 4'd3,  2'd2, 1'b0, 8'd7,  8'd4},  // R7 rmw one ref, one miss
        '{32'h3010, 4'd3,  2'd2, 1'b0, 8'd8,  8'd4},  // R7 rmw hit
        '{32'h50F8, 4'd15, 2'd0, 1'b1, 8'd9,  8'd5},  // R6 both miss, one miss
        '{32'h50C0, 4'd0,  2'd0, 1'b0, 8'd10, 8'd5},  // R6 first line allocated
        '{32'h5100, 4'd0,  2'd0, 1'b0, 8'd11, 8'd5},  // R6 second line allocated
        '{32'h60F0, 4'd15, 2'd0, 1'b0, 8'd12, 8'd6},  // R3 ends on last byte, no span
        '{32'h6100, 4'd0,  2'd0, 1'b0, 8'd13, 8'd7},  // R3 next line untouched
        '{32'h5000, 4'd0,  2'd0, 1'b0, 8'd14, 8'd8},  // R10 conflict evicts
        '{32'h1000, 4'd0,  2'd0, 1'b0, 8'd15, 8'd9},  // R10 evicted line misses
        '{32'h703C, 4'd7,  2'd3, 1'b0, 8'd15, 8'd9},  // R8 reserved kind dropped
        '{32'h7000, 4'd0,  2'd0, 1'b0, 8'd16, 8'd10}, // R8 nothing allocated
        '{32'h7040, 4'd0,  2'd0, 1'b0, 8'd17, 8'd11}, // R8 nothing allocated
        '{32'h7040, 4'd0,  2'd1, 1'b0, 8'd18, 8'd11}, // R7 write hit
        '{32'h707C, 4'd3,  2'd2, 1'b0, 8'd19, 8'd11}, // R3 exact fit, no span
        '{32'h707D, 4'd3,  2'd0, 1'b1, 8'd20, 8'd12}  // R3 one byte over, R5 merge
    };

    task automatic check(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] a, input logic [3:0] l,
                          input logic [1:0] k, output logic saw_busy);
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid  = 1'b1;
        req_addr   = a;
        req_len_m1 = l;
        req_kind   = k;
        @(negedge clk);
        req_valid = 1'b0;
        saw_busy  = busy;
        while (busy) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic sb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset ref", int'(ref_count), 0);
        check("R1 reset miss", int'(miss_count), 0);
        check("R1 reset busy", int'(busy), 0);

        for (int i = 0; i < NROW; i++) begin
            access(TBL[i].a, TBL[i].l, TBL[i].k, sb);
            check($sformatf("row %0d busy (R3)", i), int'(sb), int'(TBL[i].s));
            check($sformatf("row %0d ref", i), int'(ref_count), int'(TBL[i].r));
            check($sformatf("row %0d miss", i), int'(miss_count), int'(TBL[i].m));
        end

        // R1: clear zeroes counters and invalidates tags
        pulse_clear();
        check("R1 clear ref", int'(ref_count), 0);
        check("R1 clear miss", int'(miss_count), 0);
        access(32'h1000, 4'd0, 2'd0, sb);
        check("R1 line invalid after clear", int'(miss_count), 1);

        // R11: request during busy is ignored
        pulse_clear();
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h803C; req_len_m1 = 4'd7; req_kind = 2'd0;
        @(negedge clk);
        check("R11 busy during span", int'(busy), 1);
        req_addr = 32'h9000; req_len_m1 = 4'd0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 busy fell", int'(busy), 0);
        check("R11 ref after span", int'(ref_count), 1);
        check("R6 miss after span", int'(miss_count), 1);
        access(32'h9000, 4'd0, 2'd0, sb);
        check("R11 ignored line not allocated", int'(miss_count), 2);
        check("R11 ref after follow-up", int'(ref_count), 2);

        // R11: request in the clear cycle is ignored
        @(negedge clk);
        clr = 1'b1; req_valid = 1'b1; req_addr = 32'hA000; req_kind = 2'd0;
        @(negedge clk);
        clr = 1'b0; req_valid = 1'b0;
        check("R11 clear-cycle request ref", int'(ref_count), 0);
        access(32'hA000, 4'd0, 2'd0, sb);
        check("R11 clear-cycle line absent", int'(miss_count), 1);

        // R9: saturation
        pulse_clear();
        for (int j = 0; j < 70; j++) access(32'h1000, 4'd0, 2'd0, sb);
        check("R9 ref saturates", int'(ref_count), 63);
        check("R9 miss unchanged", int'(miss_count), 1);
        access(32'h1040, 4'd0, 2'd0, sb);
        check("R9 ref held at max", int'(ref_count), 63);
        check("R9 miss still counts", int'(miss_count), 2);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule